// File: doc/BRIEF.md
# Dual-Rate Parallel-to-Serial Word Converter

The block takes an 8-bit parallel word and emits it as an NRZ bit stream, least significant bit first. A rate input picks one of two speeds. In single-rate mode one serial bit is sent per clock period. In double-rate mode two bits are sent per clock period: the even bit while the clock is high and the odd bit while it is low. A divided word clock goes back upstream, so the source logic knows when to present the next word. One period of the word clock always covers exactly eight serial bits.

An alignment input clears the block asynchronously while it is high. Once it falls, the first falling clock edge arms the converter, and the rising edge after that starts the first word. A hold input pauses the stream at a rising edge without losing its place. While paused, the serial line stays low. Each word is latched into a holding register at the word boundary, so the source may change the parallel bus freely while a word is in flight.

Top module: `ser8_dual_rate`

## Requirements
- R1: While align_i is high, ser_o and word_clk_o are 0, and this takes effect without waiting for a clock edge.
- R2: After align_i falls, the first falling clk_i edge arms the block. The first word starts on the rising edge that follows. Nothing is sent and word_clk_o stays 0 before that rising edge.
- R3: Bit i of the serial position within a word is par_word_i[i], for i = 0 up to 7. Bit 0 is sent first.
- R4: With rate_one_i = 1, each bit lasts one full clock period. The bit changes on the falling clk_i edge that follows the rising edge which selected it.
- R5: With rate_one_i = 0, during each clock period the even bit 2j is on ser_o while clk_i is high and bit 2j+1 while clk_i is low. A word takes 4 clock periods.
- R6: word_clk_o rises when a word starts and is 1 for its first four bit positions and 0 for the last four. Its period is 8 clocks in single-rate mode and 4 clocks in double-rate mode.
- R7: par_word_i is sampled only on the rising edge at which a word starts. Changes on it at any other time do not alter the bits sent.
- R8: A rising edge with hold_i = 1 pauses the block. From that edge ser_o is 0, word_clk_o keeps its level and the position is frozen. On the first rising edge with hold_i = 0, sending resumes with the bit after the last one sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; registers update on the rising edge |
| align_i | input | 1 | Asynchronous clear while high; its fall begins the arming sequence |
| rate_one_i | input | 1 | 1: one bit per clock, 0: two bits per clock (static between clears) |
| hold_i | input | 1 | 1 at a rising edge pauses sending |
| par_word_i | input | WORD_W | Parallel word to be serialized |
| ser_o | output | 1 | Serial NRZ data |
| word_clk_o | output | 1 | Divided word-rate clock toward the source |

## Verification
The bench drives both rates, many word values and pseudo-random pause patterns against a cycle model of its own, and checks every half period. A pause that lands on a word boundary or on the start edge would expose a design that drops or repeats a bit on resume. Releasing alignment just after a falling edge catches a design that starts one cycle early. Changing the bus right after each capture catches a design that reads the bus live instead of from the holding register. Raising the clear in the middle of a word shows whether both outputs drop at once, without waiting for a clock edge.

// File: rtl/ser8_pkg.sv
`timescale 1ns/1ps
package ser8_pkg;

    typedef enum logic {
        RATE_DOUBLE = 1'b0,
        RATE_SINGLE = 1'b1
    } rate_e;

    // Serial positions consumed per clock period in the given rate
    function automatic int unsigned bits_per_clk(input logic rate_one);
        return (rate_e'(rate_one) == RATE_SINGLE) ? 1 : 2;
    endfunction

endpackage

// File: rtl/ser8_arm.sv
`timescale 1ns/1ps
// Arms the converter on the first falling clock edge after the clear is released
module ser8_arm (
    input  logic clk_i,
    input  logic align_i,
    output logic arm_o
);
    logic arm_d;
    logic arm_q;

    always_comb begin
        arm_d = 1'b1;
    end

    always_ff @(negedge clk_i or posedge align_i) begin
        if (align_i) begin
            arm_q <= 1'b0;
        end else begin
            arm_q <= arm_d;
        end
    end

    assign arm_o = arm_q;
endmodule

// File: rtl/ser8_seq.sv
`timescale 1ns/1ps
// Rising-edge sequencer: run flag, pause flag, bit position, word holding register, word clock
module ser8_seq #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              align_i,
    input  logic              arm_i,
    input  logic              rate_one_i,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] par_word_i,
    output logic              run_o,
    output logic              paused_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_clk_o
);
    typedef struct packed {
        logic              run;
        logic              paused;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] word;
        logic              wclk;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    logic [CNT_W:0] step_d;
    logic [CNT_W:0] sum_d;
    logic           adv_d;

    always_comb begin
        step_d = (CNT_W + 1)'(ser8_pkg::bits_per_clk(rate_one_i));
        adv_d  = st_q.run && !st_q.paused;
        sum_d  = {1'b0, st_q.cnt} + step_d;
        st_d   = st_q;
        if (!st_q.run) begin
            if (arm_i) begin
                st_d.run    = 1'b1;
                st_d.paused = hold_i;
                st_d.cnt    = '0;
                st_d.word   = par_word_i;
                st_d.wclk   = 1'b1;
            end
        end else begin
            st_d.paused = hold_i;
            if (adv_d) begin
                st_d.cnt  = sum_d[CNT_W-1:0];
                st_d.wclk = ~sum_d[CNT_W-1];
                if (sum_d[CNT_W]) begin
                    st_d.word = par_word_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or posedge align_i) begin
        if (align_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = st_q.run;
    assign paused_o   = st_q.paused;
    assign cnt_o      = st_q.cnt;
    assign word_o     = st_q.word;
    assign word_clk_o = st_q.wclk;
endmodule

// File: rtl/ser8_outmux.sv
`timescale 1ns/1ps
// Output bit select: falling-edge register for single rate, clock-level pick for double rate
module ser8_outmux #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              align_i,
    input  logic              rate_one_i,
    input  logic              active_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              ser_o
);
    logic             one_d;
    logic             one_q;
    logic             even_bit;
    logic             odd_bit;
    logic             two_bit;
    logic [CNT_W-1:0] odd_idx;

    always_comb begin
        odd_idx  = {cnt_i[CNT_W-1:1], 1'b1};
        even_bit = word_i[cnt_i];
        odd_bit  = word_i[odd_idx];
        one_d    = active_i & word_i[cnt_i];
        two_bit  = active_i & (clk_i ? even_bit : odd_bit);
    end

    always_ff @(negedge clk_i or posedge align_i) begin
        if (align_i) begin
            one_q <= 1'b0;
        end else begin
            one_q <= one_d;
        end
    end

    assign ser_o = rate_one_i ? one_q : two_bit;
endmodule

// File: rtl/ser8_dual_rate.sv
`timescale 1ns/1ps
module ser8_dual_rate #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              align_i,
    input  logic              rate_one_i,
    input  logic              hold_i,
    input  logic [WORD_W-1:0] par_word_i,
    output logic              ser_o,
    output logic              word_clk_o
);
    logic              arm_w;
    logic              run_w;
    logic              paused_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [WORD_W-1:0] word_w;
    logic              active_w;

    ser8_arm arm_i (
        .clk_i   (clk_i),
        .align_i (align_i),
        .arm_o   (arm_w)
    );

    ser8_seq #(.WORD_W(WORD_W)) seq_i (
        .clk_i      (clk_i),
        .align_i    (align_i),
        .arm_i      (arm_w),
        .rate_one_i (rate_one_i),
        .hold_i     (hold_i),
        .par_word_i (par_word_i),
        .run_o      (run_w),
        .paused_o   (paused_w),
        .cnt_o      (cnt_w),
        .word_o     (word_w),
        .word_clk_o (word_clk_o)
    );

    assign active_w = run_w & ~paused_w;

    ser8_outmux #(.WORD_W(WORD_W)) mux_i (
        .clk_i      (clk_i),
        .align_i    (align_i),
        .rate_one_i (rate_one_i),
        .active_i   (active_w),
        .cnt_i      (cnt_w),
        .word_i     (word_w),
        .ser_o      (ser_o)
    );
endmodule

// File: rtl/ser8_dual_rate_chk.sv
`timescale 1ns/1ps
module ser8_dual_rate_chk #(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input logic              clk_i,
    input logic              align_i,
    input logic              rate_one_i,
    input logic              run_w,
    input logic              paused_w,
    input logic [CNT_W-1:0]  cnt_w,
    input logic [WORD_W-1:0] word_w,
    input logic              ser_o,
    input logic              word_clk_o
);
    logic             past_ok;
    logic [CNT_W-1:0] step_w;

    assign step_w = rate_one_i ? CNT_W'(1) : CNT_W'(2);

    always_ff @(posedge clk_i or posedge align_i) begin
        if (align_i) past_ok <= 1'b0;
        else         past_ok <= 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (align_i)
        !run_w |-> (!word_clk_o && !ser_o && cnt_w == '0)); // R2

    AST_POS_STEP: assert property (@(posedge clk_i) disable iff (align_i)
        (past_ok && run_w && $past(run_w && !paused_w)) |-> (cnt_w == CNT_W'($past(cnt_w) + step_w))); // R5

    AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (align_i)
        (past_ok && $past(run_w && paused_w)) |-> ($stable(cnt_w) && $stable(word_clk_o))); // R8

    AST_HOLD_LOW: assert property (@(posedge clk_i) disable iff (align_i)
        (run_w && paused_w) |-> !ser_o); // R8

    AST_WCLK_RISE: assert property (@(posedge clk_i) disable iff (align_i)
        (past_ok && $rose(word_clk_o)) |-> (cnt_w == '0)); // R6

    AST_WORD_KEEP: assert property (@(posedge clk_i) disable iff (align_i)
        (past_ok && $past(run_w) && cnt_w != '0) |-> $stable(word_w)); // R7
endmodule

bind ser8_dual_rate ser8_dual_rate_chk #(.WORD_W(WORD_W)) chk_i (
    .clk_i      (clk_i),
    .align_i    (align_i),
    .rate_one_i (rate_one_i),
    .run_w      (run_w),
    .paused_w   (paused_w),
    .cnt_w      (cnt_w),
    .word_w     (word_w),
    .ser_o      (ser_o),
    .word_clk_o (word_clk_o)
);

// File: tb/ser8_dual_rate_tb.sv
`timescale 1ns/1ps
module ser8_dual_rate_tb_top;
    logic       clk_i = 1'b0;
    logic       align_i = 1'b1;
    logic       rate_one_i = 1'b1;
    logic       hold_i = 1'b0;
    logic [7:0] par_word_i = 8'h00;
    logic       ser_o;
    logic       word_clk_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk_i = ~clk_i;

    ser8_dual_rate #(.WORD_W(8)) dut_i (
        .clk_i      (clk_i),
        .align_i    (align_i),
        .rate_one_i (rate_one_i),
        .hold_i     (hold_i),
        .par_word_i (par_word_i),
        .ser_o      (ser_o),
        .word_clk_o (word_clk_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] wordval(input int seed, input int n);
        if (n == 0 && seed % 4 == 0) return 8'h01;
        if (n == 1 && seed % 4 == 0) return 8'h80;
        if (n == 0 && seed % 4 == 1) return 8'hFF;
        if (n == 0 && seed % 4 == 2) return 8'h00;
        return 8'((seed * 73 + n * 151 + n * n * 29) ^ (seed << 3));
    endfunction

    function automatic logic bitval(input int seed, input int i);
        logic [7:0] w;
        w = wordval(seed, i / 8);
        return w[i % 8];
    endfunction

    function automatic logic holdval(input int mode, input int seed, input int c);
        if (mode == 0) return 1'b0;
        return ((c * 5 + seed) % 7) < 2;
    endfunction

    // One run: clear, release, stream nwords words and compare every half period
    task automatic run_case(input logic one, input int nwords, input int seed,
                            input int hmode, input bit late);
        int  idx;
        int  step;
        bit  active;
        int  pclk;
        int  c;
        align_i    = 1'b1;
        rate_one_i = one;
        hold_i     = holdval(hmode, seed, 1);
        par_word_i = wordval(seed, 0);
        step       = one ? 1 : 2;
        @(posedge clk_i);
        #2;
        check("R1 ser_o in clear", int'(ser_o), 0);
        check("R1 word_clk_o in clear", int'(word_clk_o), 0);
        if (late) begin
            @(negedge clk_i);
            #1 align_i = 1'b0;
            @(posedge clk_i);
            #2.5;
            check("R2 no start before arming edge (clk)", int'(word_clk_o), 0);
            check("R2 no start before arming edge (ser)", int'(ser_o), 0);
        end else begin
            #1 align_i = 1'b0;
        end
        idx = 0; active = 1'b0; pclk = 0; c = 0;
        while ((idx / 8) < nwords && c < 400) begin
            @(posedge clk_i);
            c++;
            if (c == 1) begin
                idx = 0; pclk = 1;
            end else if (active) begin
                idx += step;
                pclk = ((idx % 8) < 4) ? 1 : 0;
            end
            active = !holdval(hmode, seed, c);
            #2;
            par_word_i = wordval(seed, idx / 8 + 1);
            hold_i     = holdval(hmode, seed, c + 1);
            #0.5;
            check(one ? "R6 word clock single" : "R6 word clock double", int'(word_clk_o), pclk);
            if (!one) begin
                check(active ? "R5 even bit / R3 order" : "R8 low while held",
                      int'(ser_o), active ? int'(bitval(seed, idx)) : 0);
            end
            #5;
            if (one) begin
                check(active ? "R4 single bit / R3 order / R7 capture" : "R8 low while held",
                      int'(ser_o), active ? int'(bitval(seed, idx)) : 0);
            end else begin
                check(active ? "R5 odd bit / R7 capture" : "R8 low while held",
                      int'(ser_o), active ? int'(bitval(seed, idx + 1)) : 0);
            end
        end
        // Asynchronous clear in the middle of the stream
        @(posedge clk_i);
        #3 align_i = 1'b1;
        #1;
        check("R1 async clear ser_o", int'(ser_o), 0);
        check("R1 async clear word_clk_o", int'(word_clk_o), 0);
    endtask

    initial begin
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 2; r++) begin
                for (int h = 0; h < 2; h++) begin
                    run_case(r[0], 3, s * 4 + r + h, h, s[0]);
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule